// File: doc/BRIEF.md
# Three-wire serial EEPROM command engine

This block is the device side of a three-wire serial EEPROM. A host drives a select line, a serial clock and a serial data input; the engine frames the incoming bits into a start bit, a two-bit opcode, an address field and, for commands that store data, a data word. It then reads a word back on the serial data output, writes a single word, erases a single word, fills the whole array with ones or with a given pattern, or sets and clears a programming-enable latch. The array is a behavioural memory. A strap input selects 16-bit or 8-bit words.

Each programming command opens a busy period measured in system clock cycles, which stands in for the self-timed programming time. A host that deselects the part for at least a minimum number of cycles and then selects it again while the busy period runs sees the busy/ready state on the data output. All serial inputs are sampled in the system clock domain; the serial clock is assumed to stay high and low for at least two system clock cycles each.

Top module: `tw_eeprom_engine`

## Requirements
- R1: After reset the data output enable is 0, no busy period runs and programming is disabled, so a fill command sent first starts no busy period.
- R2: A command begins on the first 1 sampled on a rising serial clock edge while selected (leading 0s are skipped), followed by a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended) and the address field, all MSB first. For opcode 00 the two top bits of the address field pick the action: 11 enable, 00 disable, 10 fill with ones, 01 fill with the data word.
- R3: Read drives the output enable high, shows a 0 first and then the addressed word MSB first, one bit per rising serial clock edge; read works whether programming is enabled or disabled.
- R4: Write stores the data word at the address when enabled; in 8-bit mode the byte address selects word (address >> 1) and lane (bit 0: 1 is bits 15:8), and only that byte changes.
- R5: With programming disabled, write, erase, fill-with-ones and fill-with-pattern leave the array unchanged.
- R6: Erase sets the addressed word (or byte in 8-bit mode) to all ones.
- R7: Fill-with-ones sets every word of the array to all ones.
- R8: Fill-with-pattern stores the data word in every location (both bytes of each word in 8-bit mode).
- R9: A programming command opens a busy period of TWP_CYC cycles starting right after its last bit; any command whose start bit arrives during that period is ignored.
- R10: When select rises after at least TCS_MIN cycles low while busy, the output enable goes high and the output reads 0 while busy and 1 once the period ends.
- R11: No status is driven if select was low for fewer than TCS_MIN cycles or rises after the busy period has ended.
- R12: Dropping select discards a partly received command; a write cut off before its last data bit changes nothing.
- R13: The address field has one more bit than the array needs (8 bits for 16-bit words, 9 for 8-bit words at the default size); its top bit is clocked in but ignored for addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org_x16 | input | 1 | Strap: 1 selects 16-bit words, 0 selects 8-bit words |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (read data or busy/ready) |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The hardest situation to reach is the busy/ready window: it needs a programming command to finish, select to drop for a counted number of cycles, and select to return before the busy period ends. The bench timestamps the rising serial clock edge of the last data bit and samples the status just before and just after the expected end of the period, and it fits a second, ignored command inside the same window. The short-deselect and late-reselect cases are driven by the same write with different deselect lengths.

// File: rtl/twe_pkg.sv
// Shared types for the three-wire EEPROM engine.
// Assumes: opcode and extended-action encodings below are the wire codes.
package twe_pkg;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SUB_DISABLE  = 2'b00,
        SUB_FILL     = 2'b01,
        SUB_CLEARALL = 2'b10,
        SUB_ENABLE   = 2'b11
    } sub_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DECODE,
        S_DATA,
        S_EXEC,
        S_RDOUT,
        S_HOLD
    } st_e;

    localparam int OPC_BITS  = 2;
    localparam int WORD_BITS = 16;
    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/twe_link.sv
// Serial-side conditioning: finds rising serial clock edges, measures how
// long select has been low, and holds the busy/ready status flag.
// Assumes: cs and sk are already synchronous to clk.
module twe_link #(
    parameter int TCS_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic busy,
    input  logic start_acc,
    output logic sk_rise,
    output logic status
);
    localparam int LW = $clog2(TCS_MIN + 1);

    logic          sk_q;
    logic          cs_q;
    logic [LW-1:0] low_cnt;
    logic          cs_rise;

    assign sk_rise = sk & ~sk_q;
    assign cs_rise = cs & ~cs_q;

    // Edge history of the two host lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    // Saturating count of cycles spent deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (cs) begin
            low_cnt <= '0;
        end else if (low_cnt != LW'(TCS_MIN)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Status flag: armed by a qualified reselect during busy, cleared on deselect or accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (!cs) begin
            status <= 1'b0;
        end else if (cs_rise && (low_cnt >= LW'(TCS_MIN)) && busy) begin
            status <= 1'b1;
        end else if (start_acc) begin
            status <= 1'b0;
        end
    end

    // R10: status can only come up while a busy period runs
    p_status_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> busy);

    // R11: deselecting removes the status
    p_status_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !status);

endmodule

// File: rtl/twe_timer.sv
// Programming period timer: a start pulse loads the period and busy stays
// high until it has counted down.
// Assumes: start never arrives while busy (the command engine blocks it).
module twe_timer #(
    parameter int TWP_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(TWP_CYC + 1);

    logic [TW-1:0] cnt;

    // Down-counter for the self-timed programming period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= TW'(TWP_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R9: a new period never starts on top of a running one
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R9: busy only begins right after a start pulse
    p_busy_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/twe_array.sv
// Behavioural word array with byte-lane writes and a whole-array fill.
// Assumes: fill data is already replicated per lane by the caller.
module twe_array #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              we_word,
    input  logic              we_all,
    input  logic              lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [15:0]       rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [15:0] mem [WORDS];

    // Array update: whole fill, full word or single byte lane.
    always_ff @(posedge clk) begin
        if (we_all) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= wdata;
            end
        end else if (we_word) begin
            if (!byte_mode) begin
                mem[waddr] <= wdata;
            end else if (lane) begin
                mem[waddr][15:8] <= wdata[15:8];
            end else begin
                mem[waddr][7:0] <= wdata[7:0];
            end
        end
    end

    assign rdata = mem[raddr];

    // R7: a fill and a single-word write are never requested together
    p_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_word && we_all));

endmodule

// File: rtl/twe_cmd.sv
// Command framer and executor: shifts in start bit, opcode, address and
// data, keeps the programming-enable latch, issues array writes and timer
// starts, and shifts read data out.
// Assumes: sk_rise is a one-cycle pulse per serial clock edge and the
// serial clock half period spans at least two clk cycles.
module twe_cmd
    import twe_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org_x16,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              di,
    input  logic              busy,
    input  logic [15:0]       rdata,
    output logic [ADDR_W-1:0] word_idx,
    output logic              lane,
    output logic              start_acc,
    output logic              prog_start,
    output logic              we_word,
    output logic              we_all,
    output logic [15:0]       wdata,
    output logic              rd_dout,
    output logic              rd_oe
);
    localparam int FIELD_W = ADDR_W + 2;
    localparam int MAXF    = (FIELD_W > WORD_BITS) ? FIELD_W : WORD_BITS;
    localparam int CNT_W   = $clog2(MAXF + 1);

    st_e                state;
    op_e                opc;
    logic [CNT_W-1:0]   left;
    logic [FIELD_W-1:0] addr_sr;
    logic [15:0]        data_sr;
    logic [15:0]        rd_sr;
    logic               prog_en;

    logic [CNT_W-1:0]   alen;
    logic [CNT_W-1:0]   dlen;
    sub_e               sub;
    logic [15:0]        wr_pat;
    logic [15:0]        rd_sel;

    // Field decode that depends on the word-size strap.
    always_comb begin
        alen     = org_x16 ? CNT_W'(ADDR_W + 1) : CNT_W'(ADDR_W + 2);
        dlen     = org_x16 ? CNT_W'(WORD_BITS) : CNT_W'(BYTE_BITS);
        sub      = org_x16 ? sub_e'(addr_sr[ADDR_W -: 2])
                           : sub_e'(addr_sr[ADDR_W+1 -: 2]);
        word_idx = org_x16 ? addr_sr[ADDR_W-1:0] : addr_sr[ADDR_W:1];
        lane     = ~org_x16 & addr_sr[0];
        wr_pat   = org_x16 ? data_sr : {data_sr[7:0], data_sr[7:0]};
        rd_sel   = org_x16 ? rdata
                           : {(lane ? rdata[15:8] : rdata[7:0]), 8'h00};
    end

    // Command state machine, enable latch and read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            opc        <= OP_EXT;
            left       <= '0;
            addr_sr    <= '0;
            data_sr    <= '0;
            rd_sr      <= '0;
            rd_dout    <= 1'b0;
            rd_oe      <= 1'b0;
            prog_en    <= 1'b0;
            start_acc  <= 1'b0;
            prog_start <= 1'b0;
            we_word    <= 1'b0;
            we_all     <= 1'b0;
            wdata      <= '0;
        end else begin
            start_acc  <= 1'b0;
            prog_start <= 1'b0;
            we_word    <= 1'b0;
            we_all     <= 1'b0;
            if (!cs) begin
                state   <= S_IDLE;
                rd_oe   <= 1'b0;
                rd_dout <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (sk_rise && di) begin
                            if (busy) begin
                                state <= S_HOLD;
                            end else begin
                                state     <= S_OPC;
                                left      <= CNT_W'(OPC_BITS);
                                start_acc <= 1'b1;
                                addr_sr   <= '0;
                                data_sr   <= '0;
                            end
                        end
                    end
                    S_OPC: begin
                        if (sk_rise) begin
                            opc <= op_e'({opc[0], di});
                            if (left == CNT_W'(1)) begin
                                state <= S_ADDR;
                                left  <= alen;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                    S_ADDR: begin
                        if (sk_rise) begin
                            addr_sr <= {addr_sr[FIELD_W-2:0], di};
                            if (left == CNT_W'(1)) begin
                                state <= S_DECODE;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                    S_DECODE: begin
                        if (opc == OP_READ) begin
                            rd_sr   <= rd_sel;
                            rd_dout <= 1'b0;
                            rd_oe   <= 1'b1;
                            left    <= dlen;
                            state   <= S_RDOUT;
                        end else if (opc == OP_WRITE ||
                                     (opc == OP_EXT && sub == SUB_FILL)) begin
                            left  <= dlen;
                            state <= S_DATA;
                        end else begin
                            state <= S_EXEC;
                        end
                    end
                    S_DATA: begin
                        if (sk_rise) begin
                            data_sr <= {data_sr[14:0], di};
                            if (left == CNT_W'(1)) begin
                                state <= S_EXEC;
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                    S_EXEC: begin
                        state <= S_HOLD;
                        case (opc)
                            OP_WRITE: if (prog_en) begin
                                we_word    <= 1'b1;
                                prog_start <= 1'b1;
                                wdata      <= wr_pat;
                            end
                            OP_ERASE: if (prog_en) begin
                                we_word    <= 1'b1;
                                prog_start <= 1'b1;
                                wdata      <= '1;
                            end
                            OP_EXT: begin
                                case (sub)
                                    SUB_ENABLE:  prog_en <= 1'b1;
                                    SUB_DISABLE: prog_en <= 1'b0;
                                    SUB_CLEARALL: if (prog_en) begin
                                        we_all     <= 1'b1;
                                        prog_start <= 1'b1;
                                        wdata      <= '1;
                                    end
                                    SUB_FILL: if (prog_en) begin
                                        we_all     <= 1'b1;
                                        prog_start <= 1'b1;
                                        wdata      <= wr_pat;
                                    end
                                    default: ;
                                endcase
                            end
                            default: ;
                        endcase
                    end
                    S_RDOUT: begin
                        if (sk_rise) begin
                            if (left != '0) begin
                                rd_dout <= rd_sr[15];
                                rd_sr   <= {rd_sr[14:0], 1'b0};
                                left    <= left - 1'b1;
                            end else begin
                                rd_oe   <= 1'b0;
                                rd_dout <= 1'b0;
                                state   <= S_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: deselect returns the framer to idle and releases the output
    p_cs_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == S_IDLE) && !rd_oe);

    // R5: programming is only started with the enable latch set
    p_prog_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> prog_en);

    // R9: no command is accepted while a busy period runs
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |-> !busy);

endmodule

// File: rtl/tw_eeprom_engine.sv
// Top level of the three-wire serial EEPROM engine: ties the serial link,
// command framer, programming timer and word array together and merges
// read data and busy/ready status onto the single data output.
// Assumes: host lines are synchronous to clk; org_x16 changes only in reset.
module tw_eeprom_engine #(
    parameter int ADDR_W  = 7,
    parameter int TWP_CYC = 400,
    parameter int TCS_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_x16,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    logic              sk_rise;
    logic              status;
    logic              busy;
    logic              start_acc;
    logic              prog_start;
    logic              we_word;
    logic              we_all;
    logic              lane;
    logic [ADDR_W-1:0] word_idx;
    logic [15:0]       wdata;
    logic [15:0]       rdata;
    logic              rd_dout;
    logic              rd_oe;

    twe_link #(.TCS_MIN(TCS_MIN)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sk        (sk),
        .busy      (busy),
        .start_acc (start_acc),
        .sk_rise   (sk_rise),
        .status    (status)
    );

    twe_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .org_x16    (org_x16),
        .cs         (cs),
        .sk_rise    (sk_rise),
        .di         (di),
        .busy       (busy),
        .rdata      (rdata),
        .word_idx   (word_idx),
        .lane       (lane),
        .start_acc  (start_acc),
        .prog_start (prog_start),
        .we_word    (we_word),
        .we_all     (we_all),
        .wdata      (wdata),
        .rd_dout    (rd_dout),
        .rd_oe      (rd_oe)
    );

    twe_timer #(.TWP_CYC(TWP_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    twe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (~org_x16),
        .we_word   (we_word),
        .we_all    (we_all),
        .lane      (lane),
        .waddr     (word_idx),
        .wdata     (wdata),
        .raddr     (word_idx),
        .rdata     (rdata)
    );

    // Output merge: read data has the pin while a read shifts out, otherwise status.
    always_comb begin
        dout_oe = rd_oe | status;
        if (rd_oe) begin
            dout = rd_dout;
        end else if (status) begin
            dout = ~busy;
        end else begin
            dout = 1'b0;
        end
    end

    // R3: read output and status never compete for the pin
    p_read_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> !status);

endmodule

// File: tb/tw_eeprom_engine_bench.sv
// Directed bench for the three-wire EEPROM engine: one task per scenario.
module tw_eeprom_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int ADDR_W     = 7;
    localparam int TWP        = 400;
    localparam int TCS        = 4;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_x16 = 1'b1;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout;
    logic dout_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t_rise = 0;
    bit done = 1'b0;

    tw_eeprom_engine #(.ADDR_W(ADDR_W), .TWP_CYC(TWP), .TCS_MIN(TCS)) u_tw_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs),
        .sk(sk), .di(di), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic int alen();
        return org_x16 ? ADDR_W + 1 : ADDR_W + 2;
    endfunction

    function automatic int dlen();
        return org_x16 ? 16 : 8;
    endfunction

    task automatic bit_io(input logic b, output logic o);
        di = b;
        tick(HALF);
        sk = 1'b1;
        t_rise = cyc;
        tick(HALF);
        o = dout;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic o;
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], o);
    endtask

    task automatic sel_off(input int n);
        cs = 1'b0;
        di = 1'b0;
        tick(n);
    endtask

    task automatic frame(input logic [1:0] op, input int addr, input logic [15:0] data,
                         input bit with_data, input int lead0);
        cs = 1'b1;
        tick(2);
        if (lead0 > 0) send(0, lead0);
        send(1, 1);
        send(op, 2);
        send(addr, alen());
        if (with_data) send(data, dlen());
    endtask

    function automatic int ext(input logic [1:0] sub);
        return int'(sub) << (alen() - 2);
    endfunction

    task automatic prog(input logic [1:0] op, input int addr, input logic [15:0] data, input bit wd);
        frame(op, addr, data, wd, 0);
        sel_off(TWP + 20);
    endtask

    task automatic rd(input int addr, input int lead0, output logic [15:0] w);
        logic o;
        frame(2'b10, addr, 16'h0, 1'b0, lead0);
        chk("R3 dummy oe", {15'b0, dout_oe}, 16'h1);
        chk("R3 dummy bit", {15'b0, dout}, 16'h0);
        w = '0;
        for (int i = 0; i < dlen(); i++) begin
            bit_io(1'b0, o);
            w = {w[14:0], o};
        end
        sel_off(TCS + 2);
    endtask

    task automatic do_reset(input logic x16);
        org_x16 = x16;
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_reset_state();
        chk("R1 oe after reset", {15'b0, dout_oe}, 16'h0);
        chk("R1 dout after reset", {15'b0, dout}, 16'h0);
    endtask

    task automatic t_locked_after_reset();
        frame(2'b00, ext(2'b10), 16'h0, 1'b0, 0);
        sel_off(TCS + 2);
        cs = 1'b1;
        tick(3);
        chk("R1 R5 no busy from locked fill", {15'b0, dout_oe}, 16'h0);
        sel_off(TCS + 2);
    endtask

    task automatic t_fill_ones();
        logic [15:0] w;
        prog(2'b00, ext(2'b11), 16'h0, 1'b0);
        prog(2'b00, ext(2'b10), 16'h0, 1'b0);
        rd(0, 0, w);   chk("R7 word 0", w, 16'hFFFF);
        rd(127, 0, w); chk("R7 word 127", w, 16'hFFFF);
    endtask

    task automatic t_write_word();
        logic [15:0] w;
        prog(2'b01, 3, 16'hA5C3, 1'b1);
        rd(3, 0, w); chk("R4 write word 3", w, 16'hA5C3);
        rd(4, 0, w); chk("R4 neighbour 4 untouched", w, 16'hFFFF);
    endtask

    task automatic t_top_bit();
        logic [15:0] w;
        rd(3 + (1 << ADDR_W), 0, w); chk("R13 top bit ignored on read", w, 16'hA5C3);
        prog(2'b01, 9 + (1 << ADDR_W), 16'h0F0F, 1'b1);
        rd(9, 0, w); chk("R13 top bit ignored on write", w, 16'h0F0F);
    endtask

    task automatic t_erase_word();
        logic [15:0] w;
        prog(2'b11, 3, 16'h0, 1'b0);
        rd(3, 0, w); chk("R6 erase word 3", w, 16'hFFFF);
    endtask

    task automatic t_status_window();
        logic [15:0] w;
        int t0;
        frame(2'b01, 10, 16'h1357, 1'b1, 0);
        t0 = t_rise;
        sel_off(TCS + 2);
        cs = 1'b1;
        tick(2);
        chk("R10 status oe while busy", {15'b0, dout_oe}, 16'h1);
        chk("R10 status busy reads 0", {15'b0, dout}, 16'h0);
        sel_off(TCS + 2);
        frame(2'b01, 11, 16'hBEEF, 1'b1, 0);
        sel_off(TCS + 2);
        cs = 1'b1;
        tick(2);
        while (cyc < t0 + TWP - 2) tick(1);
        chk("R9 still busy before period end", {14'b0, dout_oe, dout}, 16'h2);
        while (cyc < t0 + TWP + 6) tick(1);
        chk("R9 R10 ready after period", {14'b0, dout_oe, dout}, 16'h3);
        sel_off(TCS + 2);
        rd(10, 0, w);  chk("R9 write stored", w, 16'h1357);
        rd(11, 0, w);  chk("R9 command during busy ignored", w, 16'hFFFF);
    endtask

    task automatic t_no_status();
        frame(2'b01, 20, 16'h2468, 1'b1, 0);
        sel_off(1);
        cs = 1'b1;
        tick(2);
        chk("R11 short deselect gives no status", {15'b0, dout_oe}, 16'h0);
        sel_off(TWP + 20);
        cs = 1'b1;
        tick(2);
        chk("R11 reselect after period gives no status", {15'b0, dout_oe}, 16'h0);
        sel_off(TCS + 2);
    endtask

    task automatic t_abort();
        logic [15:0] w;
        cs = 1'b1;
        tick(2);
        send(1, 1);
        send(2'b01, 2);
        send(30, alen());
        send(8'h00, 8);
        sel_off(TCS + 2);
        cs = 1'b1;
        tick(2);
        chk("R12 aborted write starts no busy", {15'b0, dout_oe}, 16'h0);
        sel_off(TCS + 2);
        rd(30, 0, w);  chk("R12 aborted write leaves word", w, 16'hFFFF);
        rd(10, 2, w);  chk("R2 leading zeros skipped", w, 16'h1357);
    endtask

    task automatic t_fill_pattern();
        logic [15:0] w;
        prog(2'b00, ext(2'b01), 16'h5A69, 1'b1);
        rd(0, 0, w);   chk("R8 word 0", w, 16'h5A69);
        rd(64, 0, w);  chk("R8 word 64", w, 16'h5A69);
        rd(127, 0, w); chk("R8 word 127", w, 16'h5A69);
    endtask

    task automatic t_disabled();
        logic [15:0] w;
        prog(2'b00, ext(2'b00), 16'h0, 1'b0);
        prog(2'b01, 5, 16'h0000, 1'b1);
        rd(5, 0, w);  chk("R5 R3 write blocked, read works", w, 16'h5A69);
        prog(2'b11, 6, 16'h0, 1'b0);
        rd(6, 0, w);  chk("R5 erase blocked", w, 16'h5A69);
        prog(2'b00, ext(2'b10), 16'h0, 1'b0);
        rd(0, 0, w);  chk("R5 fill-ones blocked", w, 16'h5A69);
    endtask

    task automatic t_byte_mode();
        logic [15:0] w;
        do_reset(1'b0);
        prog(2'b00, ext(2'b11), 16'h0, 1'b0);
        prog(2'b01, 7, 16'h003C, 1'b1);
        rd(7, 0, w);   chk("R4 byte write lane 1", w, 16'h003C);
        rd(6, 0, w);   chk("R4 other lane untouched", w, 16'h0069);
        rd(7 + 256, 0, w); chk("R13 x8 top bit ignored", w, 16'h003C);
        prog(2'b00, ext(2'b01), 16'h00A5, 1'b1);
        rd(100, 0, w); chk("R8 x8 fill pattern", w, 16'h00A5);
        rd(7, 0, w);   chk("R8 x8 fill other lane", w, 16'h00A5);
    endtask

    initial begin
        do_reset(1'b1);
        t_reset_state();
        t_locked_after_reset();
        t_fill_ones();
        t_write_word();
        t_top_bit();
        t_erase_word();
        t_status_window();
        t_no_status();
        t_abort();
        t_fill_pattern();
        t_disabled();
        t_byte_mode();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule